// File: doc/BRIEF.md
# Subcube Spare Allocator for Built-In Redundancy Analysis

This block is a sequential redundancy analyzer that sits behind a memory self-test engine. During a repair run the test engine hands it the address of every failing cell, one address per cycle. The analyzer packs these addresses into a small, fixed pool of spare subcubes. Each spare is a ternary address: a value plus a mask of don't-care bits. A spare's degree is the number of its masked bits, and no spare may exceed a degree limit. Because of this, one spare can stand in for a whole row, a whole column, a tight cluster or any other aligned subcube of failing cells.

The allocation is greedy and needs no list of the faults seen so far. A spare first holds a single point address and is marked tentative. It becomes committed (essential) when a second fault joins it in a pattern that looks like a genuine defect group. Tentative spares are reconsidered only when nothing else fits. When the test engine signals the end of the run, each remaining tentative spare is widened to the full degree limit, all spares are committed, and the pass flag is raised. A fault that no spare can absorb raises the fail flag instead. The final cube list stays on the outputs, ready to be loaded into a ternary remap CAM.

Addresses are split into row bits (upper) and column bits (lower). The defaults are a 6-bit address (3 row bits and 3 column bits), 4 spares, a degree limit of 3 and a cluster radius of 1.

Top module: `cube_spare_allocator`

## Requirements
- R1: After reset the block is idle: busy, done, pass and fail are 0 and every spare is unused. A start pulse, in any phase, clears all spares and both result flags and enters the run phase (busy=1) on the next cycle.
- R2: During a run, each valid fault is offered to the spares from index 0 upward, and the first spare that accepts it takes it. An unused spare always accepts: it becomes used and tentative, and holds the fault as a point cube (value = fault address, mask = 0). At most one new spare is used per fault.
- R3: A fault that lies inside a used cube leaves all spares unchanged. Lying inside means every unmasked bit of the cube equals the fault bit.
- R4: A committed spare accepts a fault when its merged cube has degree at most n. The merged mask is the old mask OR the fault bits that differ from the unmasked value bits, and the new value bits under the mask are 0.
- R5: A tentative spare accepts a fault in the first scan, and becomes committed, when the merged degree is at most n and one more condition holds. That condition is one of: the row bits [5:3] are equal, the column bits [2:0] are equal, both the row and the column differ by at most r as unsigned numbers, or the merged degree is below n.
- R6: If no spare accepts the fault in the first scan, the lowest-index tentative spare whose merged degree is at most n takes it and becomes committed.
- R7: A fault that no spare accepts ends the run. The block sets done=1, fail=1 and pass=0 on the next cycle, and leaves the spares unchanged.
- R8: When the end input is seen during a run, each used tentative spare is widened to degree n. Unmasked bits are masked from bit 0 upward, so column bits go first, and the value bits under the mask are cleared. Every used spare is then committed, and done=1, pass=1 follow on the next cycle. A fault given in the same cycle is placed first.
- R9: Outside the run phase, the fault and end inputs have no effect on the spares or the flags.
- R10: No spare ever has more than n mask bits, and no spare value has a 1 under its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new analysis run |
| flt_valid_i | input | 1 | A failing-cell address is present this cycle |
| flt_addr_i | input | ROW_W+COL_W | Failing-cell address, row bits on top |
| flt_end_i | input | 1 | No more faults in this run |
| busy_o | output | 1 | Run phase active |
| done_o | output | 1 | Run finished, result valid |
| pass_o | output | 1 | All faults covered by the spares |
| fail_o | output | 1 | A fault could not be placed |
| spare_used_o | output | NSPARE | Per-spare used flag |
| spare_ess_o | output | NSPARE | Per-spare committed flag |
| spare_val_o | output | NSPARE*(ROW_W+COL_W) | Spare cube values, spare k at bits k*ADDR_W upward |
| spare_mask_o | output | NSPARE*(ROW_W+COL_W) | Spare cube don't-care masks, same packing |

## Verification
The properties assume that a start in the same cycle as a fault or an end takes priority and discards them, and that the fault address carries no unknown bits whenever fault valid is high. The bench drives every input on the falling clock edge and holds start for exactly one cycle. It asserts end at most once per run, and it sends faults and ends while the block is idle or finished, to probe the case where they must be ignored. The directed runs are laid out so that each acceptance rule (absorption, committed merge, row, column and cluster pivots, the second scan and the unplaceable fault) is reached on purpose. Pseudo-random runs with clustered addresses then compare every output against a behavioural model on every cycle.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Analysis phases of the allocator.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

endpackage

// File: rtl/csa_cube_eval.sv
// Evaluates one spare cube against the incoming fault: whether the fault
// is already inside, the merged cube, and acceptance in either scan.
module csa_cube_eval #(
    parameter int ADDR_W  = 6,
    parameter int ROW_W   = 3,
    parameter int MAX_DEG = 3,
    parameter int RADIUS  = 1
) (
    input  logic              used_i,
    input  logic              ess_i,
    input  logic [ADDR_W-1:0] val_i,
    input  logic [ADDR_W-1:0] mask_i,
    input  logic [ADDR_W-1:0] flt_i,
    output logic              take1_o,
    output logic              take2_o,
    output logic              hit_o,
    output logic [ADDR_W-1:0] val_o,
    output logic [ADDR_W-1:0] mask_o
);
    localparam int COL_W = ADDR_W - ROW_W;
    localparam int DEG_W = $clog2(ADDR_W + 1);

    logic [ADDR_W-1:0] diff;
    logic [DEG_W-1:0]  deg;
    logic              legal, row_same, col_same, near, pivot;
    logic [ROW_W-1:0]  rf, rc, rd;
    logic [COL_W-1:0]  cf, cc, cd;

    always_comb begin
        diff     = (flt_i ^ val_i) & ~mask_i;
        mask_o   = mask_i | diff;
        val_o    = flt_i & ~mask_o;
        deg      = DEG_W'($countones(mask_o));
        legal    = deg <= DEG_W'(MAX_DEG);
        hit_o    = (diff == '0);
        row_same = (diff[ADDR_W-1:COL_W] == '0);
        col_same = (diff[COL_W-1:0] == '0);
        rf       = flt_i[ADDR_W-1:COL_W];
        rc       = val_i[ADDR_W-1:COL_W];
        cf       = flt_i[COL_W-1:0];
        cc       = val_i[COL_W-1:0];
        rd       = (rf >= rc) ? (rf - rc) : (rc - rf);
        cd       = (cf >= cc) ? (cf - cc) : (cc - cf);
        near     = (rd <= ROW_W'(RADIUS)) && (cd <= COL_W'(RADIUS));
        pivot    = legal && (row_same || col_same || near || (deg < DEG_W'(MAX_DEG)));
        take1_o  = !used_i || hit_o || (ess_i ? legal : pivot);
        take2_o  = used_i && !ess_i && legal;
    end

endmodule

// File: rtl/csa_cube_grow.sv
// Widens a cube to the degree limit, masking free bits from bit 0 upward.
module csa_cube_grow #(
    parameter int ADDR_W  = 6,
    parameter int MAX_DEG = 3
) (
    input  logic [ADDR_W-1:0] val_i,
    input  logic [ADDR_W-1:0] mask_i,
    output logic [ADDR_W-1:0] val_o,
    output logic [ADDR_W-1:0] mask_o
);
    logic [ADDR_W-1:0] grown;
    int                fill;

    always_comb begin
        grown = mask_i;
        fill  = $countones(mask_i);
        for (int b = 0; b < ADDR_W; b++) begin
            if (!grown[b] && fill < MAX_DEG) begin
                grown[b] = 1'b1;
                fill     = fill + 1;
            end
        end
        mask_o = grown;
        val_o  = val_i & ~grown;
    end

endmodule

// File: rtl/cube_spare_allocator.sv
module cube_spare_allocator
    import csa_pkg::*;
#(
    parameter int ROW_W   = 3,
    parameter int COL_W   = 3,
    parameter int NSPARE  = 4,
    parameter int MAX_DEG = 3,
    parameter int RADIUS  = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start_i,
    input  logic                             flt_valid_i,
    input  logic [ROW_W+COL_W-1:0]           flt_addr_i,
    input  logic                             flt_end_i,
    output logic                             busy_o,
    output logic                             done_o,
    output logic                             pass_o,
    output logic                             fail_o,
    output logic [NSPARE-1:0]                spare_used_o,
    output logic [NSPARE-1:0]                spare_ess_o,
    output logic [NSPARE*(ROW_W+COL_W)-1:0]  spare_val_o,
    output logic [NSPARE*(ROW_W+COL_W)-1:0]  spare_mask_o
);
    localparam int ADDR_W = ROW_W + COL_W;

    typedef struct packed {
        logic              used;
        logic              ess;
        logic [ADDR_W-1:0] val;
        logic [ADDR_W-1:0] mask;
    } spare_t;

    typedef struct packed {
        phase_e                  phase;
        logic                    pass;
        logic                    fail;
        spare_t [NSPARE-1:0]     sp;
    } ctl_t;

    ctl_t                cur_q, nxt_d;
    spare_t [NSPARE-1:0] post_d;
    logic                lost_d, placed;

    logic [NSPARE-1:0]   take1, take2, hit;
    logic [ADDR_W-1:0]   mval  [NSPARE];
    logic [ADDR_W-1:0]   mmask [NSPARE];
    logic [ADDR_W-1:0]   gval  [NSPARE];
    logic [ADDR_W-1:0]   gmask [NSPARE];

    // One evaluator and one widener per spare.
    for (genvar g = 0; g < NSPARE; g++) begin : g_spare
        csa_cube_eval #(
            .ADDR_W(ADDR_W), .ROW_W(ROW_W), .MAX_DEG(MAX_DEG), .RADIUS(RADIUS)
        ) u_eval (
            .used_i (cur_q.sp[g].used),
            .ess_i  (cur_q.sp[g].ess),
            .val_i  (cur_q.sp[g].val),
            .mask_i (cur_q.sp[g].mask),
            .flt_i  (flt_addr_i),
            .take1_o(take1[g]),
            .take2_o(take2[g]),
            .hit_o  (hit[g]),
            .val_o  (mval[g]),
            .mask_o (mmask[g])
        );

        csa_cube_grow #(
            .ADDR_W(ADDR_W), .MAX_DEG(MAX_DEG)
        ) u_grow (
            .val_i (post_d[g].val),
            .mask_i(post_d[g].mask),
            .val_o (gval[g]),
            .mask_o(gmask[g])
        );

        assign spare_used_o[g]                  = cur_q.sp[g].used;
        assign spare_ess_o[g]                   = cur_q.sp[g].ess;
        assign spare_val_o[g*ADDR_W +: ADDR_W]  = cur_q.sp[g].val;
        assign spare_mask_o[g*ADDR_W +: ADDR_W] = cur_q.sp[g].mask;

        // R10: degree bound and clean value under the mask
        a_r10_degree_bound: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(cur_q.sp[g].mask) <= MAX_DEG);
        a_r10_value_clean: assert property (@(posedge clk) disable iff (!rst_n)
            (cur_q.sp[g].val & cur_q.sp[g].mask) == '0);
        // R2: a used spare stays used for the rest of the run
        a_r2_used_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_o && !start_i && cur_q.sp[g].used) |=> cur_q.sp[g].used);
        // R8: a passing result leaves every used spare committed
        a_r8_all_committed: assert property (@(posedge clk) disable iff (!rst_n)
            pass_o |-> (!cur_q.sp[g].used || cur_q.sp[g].ess));
    end

    // Fault placement: first scan, then second scan over tentative spares.
    always_comb begin
        post_d = cur_q.sp;
        placed = 1'b0;
        lost_d = 1'b0;
        if (cur_q.phase == PH_RUN && flt_valid_i && !start_i) begin
            for (int i = 0; i < NSPARE; i++) begin
                if (!placed && take1[i]) begin
                    placed = 1'b1;
                    if (!cur_q.sp[i].used) begin
                        post_d[i].used = 1'b1;
                        post_d[i].ess  = 1'b0;
                        post_d[i].val  = flt_addr_i;
                        post_d[i].mask = '0;
                    end else if (!hit[i]) begin
                        post_d[i].val  = mval[i];
                        post_d[i].mask = mmask[i];
                        post_d[i].ess  = 1'b1;
                    end
                end
            end
            for (int i = 0; i < NSPARE; i++) begin
                if (!placed && take2[i]) begin
                    placed         = 1'b1;
                    post_d[i].val  = mval[i];
                    post_d[i].mask = mmask[i];
                    post_d[i].ess  = 1'b1;
                end
            end
            lost_d = !placed;
        end
    end

    // Phase and result sequencing.
    always_comb begin
        nxt_d = cur_q;
        if (start_i) begin
            nxt_d.phase = PH_RUN;
            nxt_d.pass  = 1'b0;
            nxt_d.fail  = 1'b0;
            nxt_d.sp    = '0;
        end else if (cur_q.phase == PH_RUN) begin
            nxt_d.sp = post_d;
            if (lost_d) begin
                nxt_d.phase = PH_DONE;
                nxt_d.fail  = 1'b1;
            end else if (flt_end_i) begin
                for (int i = 0; i < NSPARE; i++) begin
                    if (post_d[i].used) begin
                        if (!post_d[i].ess) begin
                            nxt_d.sp[i].val  = gval[i];
                            nxt_d.sp[i].mask = gmask[i];
                        end
                        nxt_d.sp[i].ess = 1'b1;
                    end
                end
                nxt_d.phase = PH_DONE;
                nxt_d.pass  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign busy_o = (cur_q.phase == PH_RUN);
    assign done_o = (cur_q.phase == PH_DONE);
    assign pass_o = cur_q.pass;
    assign fail_o = cur_q.fail;

    // R1: start clears the pool and enters the run phase
    a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && !pass_o && !fail_o && spare_used_o == '0));
    // R2: at most one new spare per cycle of a run
    a_r2_one_new_spare: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=>
            ($countones(spare_used_o) <= $countones($past(spare_used_o)) + 1));
    // R7: a failed run keeps its result until the next start
    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> (fail_o && !pass_o));
    // R7 and R8: a finished run carries exactly one verdict
    a_r7_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o != fail_o));
    // R9: outside a run the spare pool does not move
    a_r9_hold_outside_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(cur_q.sp));

endmodule

// File: tb/cube_spare_allocator_bench.sv
module cube_spare_allocator_bench;
    localparam int AW = 6;
    localparam int NS = 4;
    localparam int ND = 3;
    localparam int RR = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, flt_valid_i = 1'b0, flt_end_i = 1'b0;
    logic [AW-1:0] flt_addr_i = '0;
    logic busy_o, done_o, pass_o, fail_o;
    logic [NS-1:0] spare_used_o, spare_ess_o;
    logic [NS*AW-1:0] spare_val_o, spare_mask_o;

    always #5 clk = ~clk;

    cube_spare_allocator #(.ROW_W(3), .COL_W(3), .NSPARE(NS), .MAX_DEG(ND), .RADIUS(RR))
    u_cube_spare_allocator (
        .clk, .rst_n, .start_i, .flt_valid_i, .flt_addr_i, .flt_end_i,
        .busy_o, .done_o, .pass_o, .fail_o,
        .spare_used_o, .spare_ess_o, .spare_val_o, .spare_mask_o
    );

    int checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";

    // ---------------- behavioural reference ----------------
    int m_used[NS], m_ess[NS], m_val[NS], m_mask[NS];
    int m_phase, m_pass, m_fail;

    function automatic int popc(int x);
        int c = 0;
        for (int b = 0; b < AW; b++) c += (x >> b) & 1;
        return c;
    endfunction

    function automatic int absd(int a, int b);
        return (a > b) ? a - b : b - a;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_pass = 0; m_fail = 0;
            for (int i = 0; i < NS; i++) begin
                m_used[i] = 0; m_ess[i] = 0; m_val[i] = 0; m_mask[i] = 0;
            end
        end else if (start_i) begin
            m_phase = 1; m_pass = 0; m_fail = 0;
            for (int i = 0; i < NS; i++) begin
                m_used[i] = 0; m_ess[i] = 0; m_val[i] = 0; m_mask[i] = 0;
            end
        end else if (m_phase == 1) begin
            int a, d, nm, dg, done_it, lost;
            a = int'(flt_addr_i); done_it = 0; lost = 0;
            if (flt_valid_i) begin
                for (int i = 0; i < NS; i++) begin
                    if (done_it == 0) begin
                        if (m_used[i] == 0) begin
                            m_used[i] = 1; m_ess[i] = 0; m_val[i] = a; m_mask[i] = 0;
                            done_it = 1;
                        end else begin
                            d = (a ^ m_val[i]) & ~m_mask[i] & 63;
                            nm = m_mask[i] | d; dg = popc(nm);
                            if (d == 0) done_it = 1;
                            else if (dg <= ND && (m_ess[i] == 1 || (d >> 3) == 0 ||
                                     (d & 7) == 0 || dg < ND ||
                                     (absd(a >> 3, m_val[i] >> 3) <= RR &&
                                      absd(a & 7, m_val[i] & 7) <= RR))) begin
                                m_mask[i] = nm; m_val[i] = a & ~nm & 63; m_ess[i] = 1;
                                done_it = 1;
                            end
                        end
                    end
                end
                for (int i = 0; i < NS; i++) begin
                    if (done_it == 0 && m_used[i] == 1 && m_ess[i] == 0) begin
                        nm = m_mask[i] | ((a ^ m_val[i]) & 63);
                        if (popc(nm) <= ND) begin
                            m_mask[i] = nm; m_val[i] = a & ~nm & 63; m_ess[i] = 1;
                            done_it = 1;
                        end
                    end
                end
                lost = (done_it == 0);
            end
            if (lost) begin
                m_phase = 2; m_fail = 1;
            end else if (flt_end_i) begin
                for (int i = 0; i < NS; i++) begin
                    if (m_used[i] == 1) begin
                        if (m_ess[i] == 0)
                            for (int b = 0; b < AW; b++)
                                if (((m_mask[i] >> b) & 1) == 0 && popc(m_mask[i]) < ND)
                                    m_mask[i] = m_mask[i] | (1 << b);
                        m_val[i] = m_val[i] & ~m_mask[i] & 63;
                        m_ess[i] = 1;
                    end
                end
                m_phase = 2; m_pass = 1;
            end
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the reference.
    logic [NS-1:0] e_used, e_ess;
    logic [NS*AW-1:0] e_val, e_mask;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NS; i++) begin
                e_used[i] = m_used[i][0];
                e_ess[i]  = m_ess[i][0];
                e_val[i*AW +: AW]  = m_val[i][AW-1:0];
                e_mask[i*AW +: AW] = m_mask[i][AW-1:0];
            end
            chk(cur_req, "busy", busy_o, m_phase == 1);
            chk(cur_req, "done", done_o, m_phase == 2);
            chk(cur_req, "pass", pass_o, m_pass);
            chk(cur_req, "fail", fail_o, m_fail);
            chk(cur_req, "used", spare_used_o, e_used);
            chk(cur_req, "ess", spare_ess_o, e_ess);
            chk(cur_req, "val", spare_val_o, e_val);
            chk(cur_req, "mask", spare_mask_o, e_mask);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(logic s, logic v, logic [AW-1:0] a, logic e);
        start_i = s; flt_valid_i = v; flt_addr_i = a; flt_end_i = e;
        @(negedge clk);
        start_i = 1'b0; flt_valid_i = 1'b0; flt_end_i = 1'b0;
    endtask

    task automatic go();          cyc(1'b1, 1'b0, '0, 1'b0); endtask
    task automatic flt(int a);    cyc(1'b0, 1'b1, AW'(a), 1'b0); endtask
    task automatic fin();         cyc(1'b0, 1'b0, '0, 1'b1); endtask

    task automatic spare(string req, int k, int u, int e, int v, int m);
        chk(req, $sformatf("spare%0d used", k), spare_used_o[k], u);
        chk(req, $sformatf("spare%0d ess", k),  spare_ess_o[k], e);
        chk(req, $sformatf("spare%0d val", k),  spare_val_o[k*AW +: AW], v);
        chk(req, $sformatf("spare%0d mask", k), spare_mask_o[k*AW +: AW], m);
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    logic [15:0] lf = 16'hACE1;
    task automatic lstep();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        chk("R1", "busy after reset", busy_o, 0);
        chk("R1", "done after reset", done_o, 0);
        chk("R1", "used after reset", spare_used_o, 0);

        // R9: faults and end before any start are ignored
        cur_req = "R9";
        flt(8'o12); fin();
        chk("R9", "used while idle", spare_used_o, 0);
        chk("R9", "done while idle", done_o, 0);

        // R2 R3 R4 R5 R8: row, column, committed merge, absorption, widening
        cur_req = "R2";
        go();
        chk("R1", "busy after start", busy_o, 1);
        flt(8'o10);
        spare("R2", 0, 1, 0, 8'o10, 0);
        cur_req = "R5";
        flt(8'o12);
        spare("R5", 0, 1, 1, 8'o10, 6'o02);
        cur_req = "R2";
        flt(8'o24); flt(8'o57);
        spare("R2", 1, 1, 0, 8'o24, 0);
        spare("R2", 2, 1, 0, 8'o57, 0);
        cur_req = "R5";
        flt(8'o77);
        spare("R5", 2, 1, 1, 8'o57, 6'o20);
        cur_req = "R3";
        flt(8'o12);
        spare("R3", 0, 1, 1, 8'o10, 6'o02);
        cur_req = "R4";
        flt(8'o13);
        spare("R4", 0, 1, 1, 8'o10, 6'o03);
        cur_req = "R8";
        fin();
        spare("R8", 1, 1, 1, 8'o20, 6'o07);
        spare("R8", 3, 0, 0, 0, 0);
        chk("R8", "pass", pass_o, 1);
        chk("R8", "done", done_o, 1);

        // R5 cluster merge; degree-3 point pair that is no pivot goes to a new spare
        cur_req = "R5";
        go();
        flt(8'o15); flt(8'o24);
        spare("R5", 0, 1, 1, 8'o04, 6'o31);
        flt(8'o00); flt(8'o13);
        spare("R2", 2, 1, 0, 8'o13, 0);
        spare("R5", 1, 1, 0, 8'o00, 0);
        cur_req = "R8";
        fin();
        spare("R8", 2, 1, 1, 8'o10, 6'o07);

        // R6: second scan merges into the first legal tentative spare
        cur_req = "R6";
        go();
        flt(8'o00); flt(8'o77); flt(8'o16); flt(8'o64);
        chk("R6", "all used", spare_used_o, 4'hF);
        flt(8'o23);
        spare("R6", 0, 1, 1, 8'o00, 6'o23);
        fin();
        spare("R8", 1, 1, 1, 8'o70, 6'o07);

        // R7: an unplaceable fault ends the run with spares held
        cur_req = "R7";
        go();
        flt(8'o00); flt(8'o07); flt(8'o70); flt(8'o77);
        flt(8'o30); flt(8'o37); flt(8'o40); flt(8'o47);
        spare("R5", 3, 1, 1, 8'o40, 6'o07);
        flt(8'o10);
        chk("R7", "fail", fail_o, 1);
        chk("R7", "pass", pass_o, 0);
        chk("R7", "done", done_o, 1);
        spare("R7", 1, 1, 1, 8'o70, 6'o07);
        // R9: after the verdict, faults and end do nothing
        cur_req = "R9";
        flt(8'o55); fin();
        chk("R9", "fail held", fail_o, 1);
        spare("R9", 2, 1, 1, 8'o30, 6'o07);

        // R8: fault with end in the same cycle; empty run
        cur_req = "R8";
        go();
        cyc(1'b0, 1'b1, 6'o12, 1'b1);
        spare("R8", 0, 1, 1, 8'o10, 6'o07);
        go(); fin();
        chk("R8", "empty pass", pass_o, 1);
        chk("R8", "empty used", spare_used_o, 0);

        // R10 and all rules: pseudo-random clustered runs against the model
        cur_req = "R10";
        for (int run = 0; run < 60; run++) begin
            int base, nf;
            lstep(); base = lf[5:0];
            lstep(); nf = lf[3:0] % 10;
            go();
            for (int k = 0; k < nf; k++) begin
                lstep();
                if (lf[9]) flt(lf[5:0]);
                else flt(base ^ (lf[5:0] & 6'b010011));
                if (lf[12]) cyc(1'b0, 1'b0, '0, 1'b0);
            end
            fin();
            lstep(); flt(lf[5:0]);
        end

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule